// File: doc/BRIEF.md
# ADC Power-Mode Sequencing Controller

This block is the digital power manager of a sampling analog-to-digital converter. Software writes a configuration register whose two low bits select the power behaviour: normal running, full power-down, sleep, or automatic sleep between conversions. The controller follows the converter core's activity. It raises BUSY for a conversion, or for a whole multi-channel sequence. It never cuts bias in the middle of a conversion. It drives bias-enable and block-enable outputs, and it raises one flag for each low-power state.

In automatic sleep the bias is dropped once the work that a start pulse launched is finished. In per-conversion sequencer mode that is each conversion. In single-pulse sequencer mode it is the last conversion of the sequence. The next start pulse wakes the converter. The input is held in sample mode for a settling stretch whose length depends on the clock mode, and only then does BUSY go high. Leaving full power-down passes through a wake period of programmable length. A write to the control-word reset address returns the block to its defaults. It then ignores the register interface for a few cycles.

Top module: `adc_pwr_seq_ctrl`

## Requirements
- R1: After power-on reset the outputs are as follows. busy, sample_hold, pd_flag, sleep_flag, asleep_flag, waking and start_drop are 0. bias_en and blocks_en are 1. cfg_q equals CFG_DEFAULT (8'h00).
- R2: The configuration register is at address 4'h1 and its mode field is data bits [1:0]. The codes are 00 normal, 01 power-down, 10 sleep and 11 auto-sleep. Power-down and sleep are entered only after the write that sets the field has been taken. Power-down clears bias_en and blocks_en and sets pd_flag. Sleep clears bias_en, keeps blocks_en at 1 and sets sleep_flag. A write to any address other than 4'h1 and 4'h4 leaves cfg_q unchanged.
- R3: A power-down or sleep request written while busy is 1 does not end the conversion. busy stays 1 until core_done, and the requested state is entered in the cycle after that core_done.
- R4: Writing 00 to the mode field leaves any low-power state, and the other bits of cfg_q keep the written values. From sleep the block returns straight to idle with bias_en at 1. From power-down, waking is 1 for exactly PD_WAKE_CYC cycles before idle is reached.
- R5: In power-down the register interface still accepts writes, and cfg_q takes the new value.
- R6: With auto-sleep enabled and seq_mode at 0, asleep_flag rises and bias_en falls in the cycle after every core_done.
- R7: With auto-sleep enabled and seq_mode at 1, a single start launches SEQ_LEN conversions. busy and bias_en stay 1 across the first SEQ_LEN-1 core_done pulses. Auto-sleep is entered only after the last of them.
- R8: From idle, busy is 1 in the cycle after the start pulse is taken. From auto-sleep, busy rises SETTLE_HALF (7) cycles later than that when full_clk is 0, and SETTLE_FULL (14) cycles later when full_clk is 1. During the settling stretch sample_hold is 0 and bias_en is 1.
- R9: A start pulse taken in power-down, sleep, the power-down wake period, the auto-sleep settling stretch, or during a conversion is ignored. start_drop is 1 for the cycle after it. In power-down and sleep such a pulse does not wake the block.
- R10: A write to address 4'h4 aborts any conversion. busy and sample_hold are 0 in the next cycle and cfg_q returns to CFG_DEFAULT. Writes are ignored for the following RST_HOLD cycles and accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_stb | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| conv_start | input | 1 | Conversion-start pulse |
| core_done | input | 1 | End of one conversion from the converter core |
| seq_mode | input | 1 | 1: one start runs a whole sequence; 0: one start per conversion |
| full_clk | input | 1 | 1: full-clock mode (long settle); 0: half-clock mode |
| busy | output | 1 | Conversion or sequence in progress |
| sample_hold | output | 1 | 1: input held for conversion; 0: input sampling |
| bias_en | output | 1 | Analog bias enable |
| blocks_en | output | 1 | Functional block enable (all but the digital interface) |
| pd_flag | output | 1 | In full power-down |
| sleep_flag | output | 1 | In sleep |
| asleep_flag | output | 1 | Auto-sleep with bias off |
| waking | output | 1 | In the power-down wake period |
| start_drop | output | 1 | A start pulse was ignored in the previous cycle |
| cfg_q | output | DATA_W | Configuration register contents |

## Verification
The bench measures the cycle in which busy rises after a start from idle. It then measures the same rise from auto-sleep in both clock modes, so a settle counter that is off by one or uses the wrong mode shows up as a latency other than 8 or 15. Power-down is requested in the middle of a conversion. A controller that acts on the request at once drops busy before core_done and is caught. Auto-sleep is run in both sequencer modes. A design that sleeps after every conversion in sequence mode drops bias between conversions, and one that never counts the sequence stays awake. Soft reset is issued during a conversion and followed at once by a write. A design that does not hold the interface in reset takes that write.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CONV   = 3'd1,
    ST_SETTLE = 3'd2,
    ST_ASLEEP = 3'd3,
    ST_SLEEP  = 3'd4,
    ST_PDOWN  = 3'd5,
    ST_PDWAKE = 3'd6,
    ST_SRST   = 3'd7
  } pwr_st_e;

  typedef enum logic [1:0] {
    PM_NORMAL = 2'b00,
    PM_PDOWN  = 2'b01,
    PM_SLEEP  = 2'b10,
    PM_AUTO   = 2'b11
  } pm_e;

endpackage

// File: rtl/adc_pwr_regif.sv
module adc_pwr_regif #(
  parameter int unsigned       ADDR_W      = 4,
  parameter int unsigned       DATA_W      = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR    = 4'h1,
  parameter logic [ADDR_W-1:0] SRST_ADDR   = 4'h4,
  parameter logic [DATA_W-1:0] CFG_DEFAULT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              if_hold,
  output logic [DATA_W-1:0] cfg_q,
  output logic              srst_pulse
);

  logic              cfg_wr;
  logic              cfg_en;
  logic [DATA_W-1:0] cfg_d;

  assign cfg_wr     = wr_stb && !if_hold && (wr_addr == CFG_ADDR);
  assign srst_pulse = wr_stb && !if_hold && (wr_addr == SRST_ADDR);

  always_comb begin
    cfg_en = cfg_wr || srst_pulse;
    cfg_d  = srst_pulse ? CFG_DEFAULT : wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_DEFAULT;
    else if (cfg_en) cfg_q <= cfg_d;
  end

endmodule

// File: rtl/adc_pwr_timer.sv
module adc_pwr_timer #(
  parameter int unsigned TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          cnt_last
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - TW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_last = (cnt_q == TW'(1));

endmodule

// File: rtl/adc_pwr_fsm.sv
module adc_pwr_fsm
  import adc_pwr_pkg::*;
#(
  parameter int unsigned TW          = 6,
  parameter int unsigned SEQ_LEN     = 2,
  parameter int unsigned PD_WAKE_CYC = 40,
  parameter int unsigned RST_HOLD    = 4,
  parameter int unsigned SETTLE_HALF = 7,
  parameter int unsigned SETTLE_FULL = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pm_e           pm,
  input  logic          srst_pulse,
  input  logic          conv_start,
  input  logic          core_done,
  input  logic          seq_mode,
  input  logic          full_clk,
  input  logic          tmr_last,
  output pwr_st_e       st_q,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          start_drop
);

  localparam int unsigned SCW = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
  localparam logic [SCW-1:0] SEQ_LAST = SCW'(SEQ_LEN - 1);

  pwr_st_e        st_d;
  logic [SCW-1:0] seq_cnt_q, seq_cnt_d;
  logic           seq_lat_q, seq_lat_d;
  logic           drop_d;

  function automatic pwr_st_e mode_target(input pm_e m, input logic from_conv);
    case (m)
      PM_PDOWN: mode_target = ST_PDOWN;
      PM_SLEEP: mode_target = ST_SLEEP;
      PM_AUTO:  mode_target = from_conv ? ST_ASLEEP : ST_IDLE;
      default:  mode_target = ST_IDLE;
    endcase
  endfunction

  always_comb begin
    st_d      = st_q;
    seq_cnt_d = seq_cnt_q;
    seq_lat_d = seq_lat_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    drop_d    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (conv_start) begin
          st_d      = ST_CONV;
          seq_lat_d = seq_mode;
          seq_cnt_d = '0;
        end else if (pm == PM_PDOWN || pm == PM_SLEEP) begin
          st_d = mode_target(pm, 1'b0);
        end
      end
      ST_ASLEEP: begin
        if (pm != PM_AUTO) begin
          st_d   = mode_target(pm, 1'b0);
          drop_d = conv_start;
        end else if (conv_start) begin
          st_d      = ST_SETTLE;
          seq_lat_d = seq_mode;
          seq_cnt_d = '0;
          tmr_load  = 1'b1;
          tmr_val   = full_clk ? TW'(SETTLE_FULL) : TW'(SETTLE_HALF);
        end
      end
      ST_SETTLE: begin
        drop_d = conv_start;
        if (tmr_last) st_d = ST_CONV;
      end
      ST_CONV: begin
        drop_d = conv_start;
        if (core_done) begin
          if (!seq_lat_q || seq_cnt_q == SEQ_LAST) begin
            seq_cnt_d = '0;
            st_d      = mode_target(pm, 1'b1);
          end else begin
            seq_cnt_d = seq_cnt_q + SCW'(1);
          end
        end
      end
      ST_SLEEP: begin
        drop_d = conv_start;
        if (pm == PM_PDOWN)      st_d = ST_PDOWN;
        else if (pm != PM_SLEEP) st_d = ST_IDLE;
      end
      ST_PDOWN: begin
        drop_d = conv_start;
        if (pm != PM_PDOWN) begin
          st_d     = ST_PDWAKE;
          tmr_load = 1'b1;
          tmr_val  = TW'(PD_WAKE_CYC);
        end
      end
      ST_PDWAKE: begin
        drop_d = conv_start;
        if (tmr_last) st_d = ST_IDLE;
      end
      default: begin
        drop_d = conv_start;
        if (tmr_last) st_d = ST_IDLE;
      end
    endcase
    if (srst_pulse) begin
      st_d      = ST_SRST;
      seq_cnt_d = '0;
      seq_lat_d = 1'b0;
      tmr_load  = 1'b1;
      tmr_val   = TW'(RST_HOLD);
      drop_d    = conv_start;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      seq_cnt_q  <= '0;
      seq_lat_q  <= 1'b0;
      start_drop <= 1'b0;
    end else begin
      st_q       <= st_d;
      seq_cnt_q  <= seq_cnt_d;
      seq_lat_q  <= seq_lat_d;
      start_drop <= drop_d;
    end
  end

endmodule

// File: rtl/adc_pwr_seq_ctrl.sv
module adc_pwr_seq_ctrl
  import adc_pwr_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 4,
  parameter int unsigned       DATA_W      = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR    = 4'h1,
  parameter logic [ADDR_W-1:0] SRST_ADDR   = 4'h4,
  parameter logic [DATA_W-1:0] CFG_DEFAULT = '0,
  parameter int unsigned       SEQ_LEN     = 2,
  parameter int unsigned       PD_WAKE_CYC = 40,
  parameter int unsigned       RST_HOLD    = 4,
  parameter int unsigned       SETTLE_HALF = 7,
  parameter int unsigned       SETTLE_FULL = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              conv_start,
  input  logic              core_done,
  input  logic              seq_mode,
  input  logic              full_clk,
  output logic              busy,
  output logic              sample_hold,
  output logic              bias_en,
  output logic              blocks_en,
  output logic              pd_flag,
  output logic              sleep_flag,
  output logic              asleep_flag,
  output logic              waking,
  output logic              start_drop,
  output logic [DATA_W-1:0] cfg_q
);

  localparam int unsigned MAX_A = (PD_WAKE_CYC > RST_HOLD) ? PD_WAKE_CYC : RST_HOLD;
  localparam int unsigned MAX_B = (SETTLE_FULL > SETTLE_HALF) ? SETTLE_FULL : SETTLE_HALF;
  localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned TW    = $clog2(MAX_C + 1);

  pwr_st_e       st_q;
  logic          srst_pulse;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_last;
  pm_e           pm;

  adc_pwr_regif #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR),
    .SRST_ADDR(SRST_ADDR), .CFG_DEFAULT(CFG_DEFAULT)
  ) regif_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .if_hold(st_q == ST_SRST), .cfg_q(cfg_q),
    .srst_pulse(srst_pulse)
  );

  assign pm = pm_e'(cfg_q[1:0]);

  adc_pwr_timer #(.TW(TW)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .cnt_last(tmr_last)
  );

  adc_pwr_fsm #(
    .TW(TW), .SEQ_LEN(SEQ_LEN), .PD_WAKE_CYC(PD_WAKE_CYC),
    .RST_HOLD(RST_HOLD), .SETTLE_HALF(SETTLE_HALF), .SETTLE_FULL(SETTLE_FULL)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .pm(pm), .srst_pulse(srst_pulse),
    .conv_start(conv_start), .core_done(core_done), .seq_mode(seq_mode),
    .full_clk(full_clk), .tmr_last(tmr_last), .st_q(st_q),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .start_drop(start_drop)
  );

  always_comb begin
    busy        = (st_q == ST_CONV);
    sample_hold = (st_q == ST_CONV);
    pd_flag     = (st_q == ST_PDOWN);
    sleep_flag  = (st_q == ST_SLEEP);
    asleep_flag = (st_q == ST_ASLEEP);
    waking      = (st_q == ST_PDWAKE);
    bias_en     = !(pd_flag || sleep_flag || asleep_flag);
    blocks_en   = !pd_flag;
  end

endmodule

// File: rtl/adc_pwr_seq_ctrl_chk.sv
module adc_pwr_seq_ctrl_chk #(
  parameter int unsigned       ADDR_W    = 4,
  parameter int unsigned       DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 4'h1,
  parameter logic [ADDR_W-1:0] SRST_ADDR = 4'h4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              conv_start,
  input logic              core_done,
  input logic              busy,
  input logic              sample_hold,
  input logic              bias_en,
  input logic              blocks_en,
  input logic              pd_flag,
  input logic              asleep_flag,
  input logic              start_drop,
  input logic [DATA_W-1:0] cfg_q
);

  logic srst_wr;
  assign srst_wr = wr_stb && (wr_addr == SRST_ADDR);

  // R2
  pdown_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_flag |-> (!bias_en && !blocks_en));

  // R3
  conv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !core_done && !srst_wr) |=> busy);

  // R5
  pdown_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_flag && wr_stb && wr_addr == CFG_ADDR) |=> (cfg_q == $past(wr_data)));

  // R8
  wake_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep_flag |=> !busy);

  // R9
  drop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_drop |-> $past(conv_start));

  // R10
  srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_wr |=> (!busy && !sample_hold && cfg_q == '0));

endmodule

bind adc_pwr_seq_ctrl adc_pwr_seq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
  .wr_data(wr_data), .conv_start(conv_start), .core_done(core_done),
  .busy(busy), .sample_hold(sample_hold), .bias_en(bias_en),
  .blocks_en(blocks_en), .pd_flag(pd_flag), .asleep_flag(asleep_flag),
  .start_drop(start_drop), .cfg_q(cfg_q)
);

// File: tb/adc_pwr_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_pwr_seq_ctrl_tb_top;

  localparam int SEQ_N   = 3;
  localparam int WAKE_N  = 20;
  localparam int HOLD_N  = 4;
  localparam int HALF_N  = 7;
  localparam int FULL_N  = 14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_stb = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       conv_start = 1'b0;
  logic       core_done = 1'b0;
  logic       seq_mode = 1'b0;
  logic       full_clk = 1'b0;
  logic       busy, sample_hold, bias_en, blocks_en;
  logic       pd_flag, sleep_flag, asleep_flag, waking, start_drop;
  logic [7:0] cfg_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;
  int lat;
  logic s1_samp, s1_bias;

  always #2 clk = ~clk;

  adc_pwr_seq_ctrl #(
    .SEQ_LEN(SEQ_N), .PD_WAKE_CYC(WAKE_N), .RST_HOLD(HOLD_N),
    .SETTLE_HALF(HALF_N), .SETTLE_FULL(FULL_N)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .conv_start(conv_start), .core_done(core_done),
    .seq_mode(seq_mode), .full_clk(full_clk), .busy(busy),
    .sample_hold(sample_hold), .bias_en(bias_en), .blocks_en(blocks_en),
    .pd_flag(pd_flag), .sleep_flag(sleep_flag), .asleep_flag(asleep_flag),
    .waking(waking), .start_drop(start_drop), .cfg_q(cfg_q)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // pulse a start, return cycles until busy is seen
  task automatic start_lat(output int n);
    @(negedge clk);
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    n = 1;
    s1_samp = sample_hold;
    s1_bias = bias_en;
    while (!busy && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_done();
    @(negedge clk);
    core_done = 1'b1;
    @(negedge clk);
    core_done = 1'b0;
  endtask

  task automatic pulse_ignored(input string tag);
    @(negedge clk);
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    chk({tag, " start_drop"}, start_drop, 1);
    chk({tag, " busy stays low"}, busy, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 sample_hold", sample_hold, 0);
    chk("R1 bias_en", bias_en, 1);
    chk("R1 blocks_en", blocks_en, 1);
    chk("R1 flags", {pd_flag, sleep_flag, asleep_flag, waking, start_drop}, 0);
    chk("R1 cfg_q", cfg_q, 8'h00);
  endtask

  task automatic t_idle_conv();
    start_lat(lat);
    chk("R8 idle latency", lat, 1);
    chk("R8 idle sample_hold", sample_hold, 1);
    pulse_done();
    chk("R8 idle done busy", busy, 0);
  endtask

  task automatic t_pdown();
    wr(4'h1, 8'hA9);
    idle_cycles(1);
    chk("R2 pd_flag", pd_flag, 1);
    chk("R2 pd bias_en", bias_en, 0);
    chk("R2 pd blocks_en", blocks_en, 0);
    pulse_ignored("R9 pd");
    idle_cycles(2);
    chk("R9 pd no wake", pd_flag, 1);
    wr(4'h1, 8'hE1);
    chk("R5 pd write accepted", cfg_q, 8'hE1);
    chk("R5 still pd", pd_flag, 1);
    wr(4'h1, 8'hE0);
    begin
      int cnt = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (waking) cnt++;
        else if (cnt > 0) break;
      end
      chk("R4 wake cycles", cnt, WAKE_N);
    end
    chk("R4 pd exit bias_en", bias_en, 1);
    chk("R4 pd exit flag", pd_flag, 0);
    chk("R4 upper bits kept", cfg_q, 8'hE0);
    wr(4'h2, 8'h33);
    idle_cycles(1);
    chk("R2 other address ignored", cfg_q, 8'hE0);
  endtask

  task automatic t_sleep();
    wr(4'h1, 8'h02);
    idle_cycles(1);
    chk("R2 sleep_flag", sleep_flag, 1);
    chk("R2 sleep bias_en", bias_en, 0);
    chk("R2 sleep blocks_en", blocks_en, 1);
    pulse_ignored("R9 sleep");
    idle_cycles(2);
    chk("R9 sleep no wake", sleep_flag, 1);
    wr(4'h1, 8'h00);
    idle_cycles(1);
    chk("R4 sleep exit flag", sleep_flag, 0);
    chk("R4 sleep exit bias_en", bias_en, 1);
  endtask

  task automatic t_defer();
    start_lat(lat);
    chk("R3 conv started", busy, 1);
    wr(4'h1, 8'h01);
    idle_cycles(3);
    chk("R3 busy held", busy, 1);
    chk("R3 pd deferred", pd_flag, 0);
    pulse_ignored_busy();
    pulse_done();
    chk("R3 busy after done", busy, 0);
    chk("R3 pd after done", pd_flag, 1);
    wr(4'h1, 8'h00);
    idle_cycles(WAKE_N + 3);
    chk("R4 back to idle", waking, 0);
  endtask

  task automatic pulse_ignored_busy();
    @(negedge clk);
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    chk("R9 conv start_drop", start_drop, 1);
    chk("R9 conv busy kept", busy, 1);
  endtask

  task automatic t_auto_single();
    seq_mode = 1'b0;
    full_clk = 1'b0;
    wr(4'h1, 8'h03);
    idle_cycles(2);
    chk("R6 enable no sleep yet", asleep_flag, 0);
    start_lat(lat);
    chk("R8 first from idle", lat, 1);
    pulse_done();
    chk("R6 asleep after done", asleep_flag, 1);
    chk("R6 bias off", bias_en, 0);
    start_lat(lat);
    chk("R8 half-clock latency", lat, HALF_N + 1);
    chk("R8 settle sample_hold", s1_samp, 0);
    chk("R8 settle bias_en", s1_bias, 1);
    pulse_done();
    chk("R6 asleep again", asleep_flag, 1);
    full_clk = 1'b1;
    @(negedge clk);
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    @(negedge clk);
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    chk("R9 settle start_drop", start_drop, 1);
    lat = 3;
    while (!busy && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk("R8 full-clock latency", lat, FULL_N + 1);
    pulse_done();
    chk("R6 asleep full", asleep_flag, 1);
    full_clk = 1'b0;
  endtask

  task automatic t_auto_seq();
    seq_mode = 1'b1;
    start_lat(lat);
    chk("R7 seq wake latency", lat, HALF_N + 1);
    for (int k = 0; k < SEQ_N - 1; k++) begin
      pulse_done();
      chk("R7 busy mid sequence", busy, 1);
      chk("R7 bias mid sequence", bias_en, 1);
    end
    pulse_done();
    chk("R7 asleep after last", asleep_flag, 1);
    chk("R7 busy after last", busy, 0);
    seq_mode = 1'b0;
  endtask

  task automatic t_srst();
    wr(4'h1, 8'h54);
    idle_cycles(1);
    chk("R4 asleep exit", asleep_flag, 0);
    start_lat(lat);
    chk("R10 conv running", busy, 1);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = 4'h4; wr_data = 8'h00;
    @(negedge clk);
    wr_addr = 4'h1; wr_data = 8'h08;
    chk("R10 busy aborted", busy, 0);
    chk("R10 sample_hold", sample_hold, 0);
    chk("R10 cfg default", cfg_q, 8'h00);
    @(negedge clk);
    wr_stb = 1'b0;
    chk("R10 write in hold ignored", cfg_q, 8'h00);
    idle_cycles(HOLD_N);
    wr(4'h1, 8'h08);
    chk("R10 write after hold", cfg_q, 8'h08);
  endtask

  initial begin
    #(4 * 200000);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle_cycles(3);
    rst_n = 1'b1;
    idle_cycles(2);
    t_reset();
    t_idle_conv();
    t_pdown();
    t_sleep();
    t_defer();
    t_auto_single();
    t_auto_seq();
    t_srst();
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule